// File: doc/BRIEF.md
# Cache Line Status Bit Array

This block keeps the status bits of every line of a set-associative cache, apart from the tags and the data. Each line has three stored bits: a validity bit, a companion bit that normally holds the inverse of the validity bit, and a dirty bit. A line counts as valid only when the two validity bits disagree in the right direction. A single flipped storage bit therefore cannot turn a junk line into a valid one.

The cache controller updates the array through three ports. A fill port loads a line. A write-hit port marks a line as modified. An invalidate port empties a line. A victim query port names a set and a way. One cycle later it reports whether that line may be overwritten at once or must first be written back to memory. The all-dirty configuration input serves caches that keep no modify information: every fill then records the line as dirty.

A fault-model port flips one chosen stored validity bit. It lets the pair protection be exercised through the normal interface.

Top module: `line_status_array`

## Requirements
- R1: After reset, every line reads invalid and clean: the query reports line valid 0, dirty 0, overwrite-allowed 1 and write-back 0. The response valid output stays 0 while no query is made.
- R2: A fill writes validity 1, companion 0 and dirty 0 to the addressed line when the all-dirty input is 0. A query then reports the line valid and clean.
- R3: A line reads valid only when its validity bit is 1 and its companion bit is 0. Flipping either bit alone makes the line read invalid. The fault port selects the bit with upset_bit: 0 selects the validity bit, 1 selects the companion.
- R4: A write-hit sets the dirty bit of a line that reads valid. A write-hit to a line that reads invalid leaves that line invalid and clean.
- R5: For the queried line, write-back = valid AND dirty, and overwrite-allowed = NOT write-back. The reported dirty value is valid AND dirty. The two decision outputs are never both 1.
- R6: With the all-dirty input at 1, a fill writes dirty 1, so a later query on that line asks for a write-back.
- R7: An invalidate writes validity 0, companion 1 and dirty 0 to the addressed line.
- R8: Operations on the same line in the same cycle follow the order fill, then invalidate, then write-hit. A fill together with a write-hit leaves the line valid and clean (all-dirty at 0). A fill together with an invalidate leaves the line valid. An invalidate together with a write-hit leaves the line invalid and clean.
- R9: The response valid output is high exactly one cycle after a query request. Its fields show the stored bits of the requested line as they stand in that response cycle, which includes any update made at the same clock edge.
- R10: An operation changes only the line given by its set and way. A neighbouring way in the same set keeps its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_all_dirty | input | 1 | 1: every fill records the line as dirty |
| fill_vld | input | 1 | Fill request |
| fill_set | input | SET_W | Fill set index |
| fill_way | input | WAY_W | Fill way |
| wr_vld | input | 1 | Write-hit request |
| wr_set | input | SET_W | Write-hit set index |
| wr_way | input | WAY_W | Write-hit way |
| inv_vld | input | 1 | Invalidate request |
| inv_set | input | SET_W | Invalidate set index |
| inv_way | input | WAY_W | Invalidate way |
| upset_vld | input | 1 | Fault model: flip one stored validity bit |
| upset_set | input | SET_W | Fault set index |
| upset_way | input | WAY_W | Fault way |
| upset_bit | input | 1 | 0 flips the validity bit, 1 flips the companion bit |
| qry_vld | input | 1 | Victim query request |
| qry_set | input | SET_W | Query set index |
| qry_way | input | WAY_W | Query way |
| rsp_vld | output | 1 | Query response valid, one cycle after the request |
| rsp_line_valid | output | 1 | Queried line reads valid |
| rsp_dirty | output | 1 | Queried line is valid and dirty |
| rsp_overwrite_ok | output | 1 | Victim may be replaced at once |
| rsp_writeback | output | 1 | Victim needs a write-back first |

## Verification
Two pairs of functions can meet in one cycle. The first pair is two updates on the same line. The bench drives fill with write-hit, fill with invalidate, and invalidate with write-hit on one line in one cycle. It then judges the stored result through a later query against the fixed order fill, invalidate, write-hit. The second pair is a query issued in the same cycle as a write-hit on the line it names. The response must already show the line dirty and ask for a write-back. The bench also clears neighbouring lines and checks them to confirm that the updates stayed on their own line.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    // stored status of one cache line
    typedef struct packed {
        logic vbit;   // validity bit
        logic vbar;   // complemented companion of vbit
        logic dirty;  // contents differ from memory
    } lsa_line_t;

    typedef enum logic [1:0] {
        LSA_OP_NONE  = 2'd0,
        LSA_OP_FILL  = 2'd1,
        LSA_OP_INVAL = 2'd2,
        LSA_OP_MARK  = 2'd3
    } lsa_op_e;

    localparam lsa_line_t LSA_LINE_EMPTY = '{vbit: 1'b0, vbar: 1'b1, dirty: 1'b0};

    // the pair must disagree, with vbit high
    function automatic logic lsa_is_valid(input lsa_line_t l);
        return l.vbit & ~l.vbar;
    endfunction

    // same-line priority: fill, then invalidate, then write-hit
    function automatic lsa_op_e lsa_pick_op(input logic fill, input logic inval,
                                            input logic mark);
        if (fill)       return LSA_OP_FILL;
        else if (inval) return LSA_OP_INVAL;
        else if (mark)  return LSA_OP_MARK;
        else            return LSA_OP_NONE;
    endfunction

    function automatic lsa_line_t lsa_apply(input lsa_line_t cur, input lsa_op_e op,
                                            input logic all_dirty);
        lsa_line_t n;
        n = cur;
        case (op)
            LSA_OP_FILL: begin
                n.vbit  = 1'b1;
                n.vbar  = 1'b0;
                n.dirty = all_dirty;
            end
            LSA_OP_INVAL: n = LSA_LINE_EMPTY;
            LSA_OP_MARK: begin
                if (lsa_is_valid(cur)) n.dirty = 1'b1;
            end
            default: n = cur;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/lsa_line_select.sv
module lsa_line_select #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int LINES = NUM_SETS * NUM_WAYS
) (
    input  logic             en,
    input  logic [SET_W-1:0] set_idx,
    input  logic [WAY_W-1:0] way_idx,
    output logic [LINES-1:0] hit
);
    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
            assign hit[s*NUM_WAYS + w] = en && (set_idx == SET_W'(s))
                                            && (way_idx == WAY_W'(w));
        end
    end
endmodule

// File: rtl/lsa_line_cell.sv
module lsa_line_cell
    import lsa_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cfg_all_dirty,
    input  logic      fill_hit,
    input  logic      inv_hit,
    input  logic      wr_hit,
    input  logic      flip_v,
    input  logic      flip_c,
    output lsa_line_t stat
);
    lsa_line_t nxt;
    lsa_op_e   op;

    always_comb begin
        op       = lsa_pick_op(fill_hit, inv_hit, wr_hit);
        nxt      = lsa_apply(stat, op, cfg_all_dirty);
        // fault model acts on the stored bits
        nxt.vbit = nxt.vbit ^ flip_v;
        nxt.vbar = nxt.vbar ^ flip_c;
    end

    always_ff @(posedge clk) begin
        if (rst) stat <= LSA_LINE_EMPTY;
        else     stat <= nxt;
    end

    // R2: a fill leaves a valid pair behind
    p_fill_valid_r2: assert property (@(posedge clk) disable iff (rst)
        (fill_hit && !flip_v && !flip_c) |=> (stat.vbit && !stat.vbar));

    // R3: without a fault, a consistent pair stays consistent
    p_pair_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (!flip_v && !flip_c && (stat.vbit != stat.vbar)) |=> (stat.vbit != stat.vbar));

    // R4: write-hit on a valid line marks it dirty
    p_mark_dirty_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !fill_hit && !inv_hit && lsa_is_valid(stat)) |=> stat.dirty);

    // R6: all-dirty mode fills dirty
    p_all_dirty_r6: assert property (@(posedge clk) disable iff (rst)
        (fill_hit && cfg_all_dirty) |=> stat.dirty);

    // R7: invalidate empties the line
    p_inval_empty_r7: assert property (@(posedge clk) disable iff (rst)
        (inv_hit && !fill_hit && !flip_v && !flip_c)
        |=> (!stat.vbit && stat.vbar && !stat.dirty));

    // R8: fill beats a write-hit in the same cycle
    p_fill_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (fill_hit && wr_hit && !cfg_all_dirty) |=> !stat.dirty);
endmodule

// File: rtl/lsa_victim_query.sv
module lsa_victim_query
    import lsa_pkg::*;
#(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int LINES = NUM_SETS * NUM_WAYS,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  qry_vld,
    input  logic [SET_W-1:0]      qry_set,
    input  logic [WAY_W-1:0]      qry_way,
    input  lsa_line_t [LINES-1:0] stat_all,
    output logic                  rsp_vld,
    output logic                  rsp_line_valid,
    output logic                  rsp_dirty,
    output logic                  rsp_overwrite_ok,
    output logic                  rsp_writeback
);
    logic [IDX_W-1:0] q_idx;
    lsa_line_t        sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld <= 1'b0;
            q_idx   <= '0;
        end else begin
            rsp_vld <= qry_vld;
            if (qry_vld)
                q_idx <= IDX_W'(qry_set) * IDX_W'(NUM_WAYS) + IDX_W'(qry_way);
        end
    end

    // combinational on the stored bits of the latched line
    always_comb begin
        sel              = stat_all[q_idx];
        rsp_line_valid   = lsa_is_valid(sel);
        rsp_dirty        = rsp_line_valid & sel.dirty;
        rsp_writeback    = rsp_dirty;
        rsp_overwrite_ok = ~rsp_writeback;
    end

    // R9: response exactly one cycle after the request
    p_rsp_follows_r9: assert property (@(posedge clk) disable iff (rst)
        qry_vld |=> rsp_vld);
    p_rsp_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !qry_vld |=> !rsp_vld);

    // R5: a write-back is only requested for a valid line
    p_wb_needs_valid_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp_writeback) |-> (rsp_line_valid && !rsp_overwrite_ok));
endmodule

// File: rtl/line_status_array.sv
module line_status_array
    import lsa_pkg::*;
#(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int LINES = NUM_SETS * NUM_WAYS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_all_dirty,
    input  logic             fill_vld,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    input  logic             wr_vld,
    input  logic [SET_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic             inv_vld,
    input  logic [SET_W-1:0] inv_set,
    input  logic [WAY_W-1:0] inv_way,
    input  logic             upset_vld,
    input  logic [SET_W-1:0] upset_set,
    input  logic [WAY_W-1:0] upset_way,
    input  logic             upset_bit,
    input  logic             qry_vld,
    input  logic [SET_W-1:0] qry_set,
    input  logic [WAY_W-1:0] qry_way,
    output logic             rsp_vld,
    output logic             rsp_line_valid,
    output logic             rsp_dirty,
    output logic             rsp_overwrite_ok,
    output logic             rsp_writeback
);
    logic [LINES-1:0]      fill_hit, wr_hit, inv_hit, upset_hit;
    lsa_line_t [LINES-1:0] stat_all;

    lsa_line_select #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_sel_fill (
        .en(fill_vld), .set_idx(fill_set), .way_idx(fill_way), .hit(fill_hit));
    lsa_line_select #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_sel_wr (
        .en(wr_vld), .set_idx(wr_set), .way_idx(wr_way), .hit(wr_hit));
    lsa_line_select #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_sel_inv (
        .en(inv_vld), .set_idx(inv_set), .way_idx(inv_way), .hit(inv_hit));
    lsa_line_select #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_sel_upset (
        .en(upset_vld), .set_idx(upset_set), .way_idx(upset_way), .hit(upset_hit));

    for (genvar i = 0; i < LINES; i++) begin : g_line
        lsa_line_cell u_cell (
            .clk           (clk),
            .rst           (rst),
            .cfg_all_dirty (cfg_all_dirty),
            .fill_hit      (fill_hit[i]),
            .inv_hit       (inv_hit[i]),
            .wr_hit        (wr_hit[i]),
            .flip_v        (upset_hit[i] & ~upset_bit),
            .flip_c        (upset_hit[i] & upset_bit),
            .stat          (stat_all[i])
        );
    end

    lsa_victim_query #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_query (
        .clk              (clk),
        .rst              (rst),
        .qry_vld          (qry_vld),
        .qry_set          (qry_set),
        .qry_way          (qry_way),
        .stat_all         (stat_all),
        .rsp_vld          (rsp_vld),
        .rsp_line_valid   (rsp_line_valid),
        .rsp_dirty        (rsp_dirty),
        .rsp_overwrite_ok (rsp_overwrite_ok),
        .rsp_writeback    (rsp_writeback)
    );

    // R10: at most one line selected per port
    p_one_line_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fill_hit) && $onehot0(wr_hit) && $onehot0(inv_hit));
endmodule

// File: tb/test_line_status_array.sv
module test_line_status_array;
    localparam int NS = 16;
    localparam int NW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_all_dirty = 1'b0;
    logic fill_vld = 1'b0, wr_vld = 1'b0, inv_vld = 1'b0, upset_vld = 1'b0, qry_vld = 1'b0;
    logic [3:0] fill_set = '0, wr_set = '0, inv_set = '0, upset_set = '0, qry_set = '0;
    logic [1:0] fill_way = '0, wr_way = '0, inv_way = '0, upset_way = '0, qry_way = '0;
    logic upset_bit = 1'b0;
    logic rsp_vld, rsp_line_valid, rsp_dirty, rsp_overwrite_ok, rsp_writeback;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    line_status_array #(.NUM_SETS(NS), .NUM_WAYS(NW)) i_line_status_array (
        .clk(clk), .rst(rst), .cfg_all_dirty(cfg_all_dirty),
        .fill_vld(fill_vld), .fill_set(fill_set), .fill_way(fill_way),
        .wr_vld(wr_vld), .wr_set(wr_set), .wr_way(wr_way),
        .inv_vld(inv_vld), .inv_set(inv_set), .inv_way(inv_way),
        .upset_vld(upset_vld), .upset_set(upset_set), .upset_way(upset_way),
        .upset_bit(upset_bit),
        .qry_vld(qry_vld), .qry_set(qry_set), .qry_way(qry_way),
        .rsp_vld(rsp_vld), .rsp_line_valid(rsp_line_valid), .rsp_dirty(rsp_dirty),
        .rsp_overwrite_ok(rsp_overwrite_ok), .rsp_writeback(rsp_writeback)
    );

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // one cycle of operations, all aimed at the same line
    task automatic ops(input bit f, input bit w, input bit i, input int s, input int wy);
        @(negedge clk);
        fill_vld = f; wr_vld = w; inv_vld = i;
        fill_set = 4'(s); wr_set = 4'(s); inv_set = 4'(s);
        fill_way = 2'(wy); wr_way = 2'(wy); inv_way = 2'(wy);
        @(negedge clk);
        fill_vld = 1'b0; wr_vld = 1'b0; inv_vld = 1'b0;
    endtask

    task automatic upset(input int s, input int wy, input bit b);
        @(negedge clk);
        upset_vld = 1'b1; upset_set = 4'(s); upset_way = 2'(wy); upset_bit = b;
        @(negedge clk);
        upset_vld = 1'b0;
    endtask

    // vector: {rsp_vld, valid, dirty, overwrite_ok, writeback}
    function automatic logic [4:0] expv(input bit v, input bit d);
        return {1'b1, v, v & d, ~(v & d), v & d};
    endfunction

    task automatic query(input string tag, input int s, input int wy, input bit v, input bit d);
        @(negedge clk);
        qry_vld = 1'b1; qry_set = 4'(s); qry_way = 2'(wy);
        @(negedge clk);
        check(tag, {rsp_vld, rsp_line_valid, rsp_dirty, rsp_overwrite_ok, rsp_writeback},
              expv(v, d));
        qry_vld = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 idle rsp_vld", {4'b0, rsp_vld}, 5'b0);
        query("R1 line 0/0 empty", 0, 0, 0, 0);
        query("R1 line 15/3 empty", 15, 3, 0, 0);
        @(negedge clk);
        check("R9 rsp_vld drops", {4'b0, rsp_vld}, 5'b0);
    endtask

    task automatic t_fill_mark();
        ops(1, 0, 0, 2, 1);
        query("R2 fill clean", 2, 1, 1, 0);
        ops(0, 1, 0, 2, 1);
        query("R4 R5 write-hit needs writeback", 2, 1, 1, 1);
        query("R10 neighbour untouched", 2, 0, 0, 0);
        ops(0, 1, 0, 3, 0);
        query("R4 write-hit on invalid ignored", 3, 0, 0, 0);
    endtask

    task automatic t_inval();
        ops(0, 0, 1, 2, 1);
        query("R7 invalidate empties dirty line", 2, 1, 0, 0);
    endtask

    task automatic t_all_dirty();
        cfg_all_dirty = 1'b1;
        ops(1, 0, 0, 5, 2);
        cfg_all_dirty = 1'b0;
        query("R6 all-dirty fill", 5, 2, 1, 1);
        ops(1, 0, 0, 5, 3);
        query("R2 normal fill after mode off", 5, 3, 1, 0);
    endtask

    task automatic t_same_cycle();
        ops(1, 1, 0, 6, 3);
        query("R8 fill beats write-hit", 6, 3, 1, 0);
        ops(1, 0, 1, 7, 2);
        query("R8 fill beats invalidate", 7, 2, 1, 0);
        ops(0, 1, 0, 7, 2);
        ops(0, 1, 1, 7, 2);
        query("R8 invalidate beats write-hit", 7, 2, 0, 0);
    endtask

    task automatic t_upset();
        ops(1, 0, 0, 8, 0);
        ops(0, 1, 0, 8, 0);
        upset(8, 0, 1);
        query("R3 companion flip hides dirty line", 8, 0, 0, 0);
        upset(9, 1, 0);
        query("R3 validity flip on empty line", 9, 1, 0, 0);
        ops(1, 0, 0, 10, 0);
        upset(10, 0, 0);
        query("R3 validity flip on valid line", 10, 0, 0, 0);
        ops(1, 0, 0, 10, 0);
        query("R3 refill restores pair", 10, 0, 1, 0);
    endtask

    task automatic t_query_race();
        ops(1, 0, 0, 11, 2);
        @(negedge clk);
        wr_vld = 1'b1; wr_set = 4'd11; wr_way = 2'd2;
        qry_vld = 1'b1; qry_set = 4'd11; qry_way = 2'd2;
        @(negedge clk);
        wr_vld = 1'b0;
        check("R9 query sees same-edge write-hit",
              {rsp_vld, rsp_line_valid, rsp_dirty, rsp_overwrite_ok, rsp_writeback},
              expv(1, 1));
        qry_vld = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fill_mark();
        t_inval();
        t_all_dirty();
        t_same_cycle();
        t_upset();
        t_query_race();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule